// File: doc/BRIEF.md
# Two-Register Stack Machine Core

This block is a compact execution core for a zero-address stack instruction set. Only the two topmost stack entries are held in flip-flops. Every deeper entry lives in a reserved region of data memory. The core moves values between the two regions itself: a push that finds both registers occupied first writes the lower one out to the spill region. An operation that needs more register entries than it has reads them back from memory before it executes.

Instructions are fetched one byte per cycle from a synchronous instruction memory. Four operations exist. A push (3 bytes) reads a 16-bit word from an absolute address onto the stack. A pop (3 bytes) writes the top of the stack to an absolute address. Add and subtract (1 byte each) replace the two top entries with one result. A halt byte stops the core. Both memories are synchronous with one cycle of read latency, and the data port makes at most one access per cycle. The stack overflow and underflow conditions each raise a sticky flag and stop execution.

Top module: `sm_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the core fetches from address 0 and drives both data strobes low. In those cycles halted, underflow and overflow are low.
- R2: The byte at offset 0 of an instruction is its opcode: 0x01 push, 0x02 pop, 0x10 add, 0x11 sub, 0xFF halt. Push and pop are followed by a 16-bit address, low byte first. Instruction bytes are fetched in sequence, and the fetch address advances by at most one per cycle.
- R3: A push places the word at its address on top of the stack. A pop writes the top word to its address and removes it from the stack.
- R4: Add replaces the two top entries with their 16-bit sum. Sub replaces them with (second entry − top entry) modulo 2^16, so that pushing B, pushing C and then subtracting yields B−C.
- R5: Opcode 0xFF, and any byte that is not a defined opcode, raises halted. Once halted, the core stays halted until reset, makes no further data access and holds its fetch address.
- R6: A push that finds two register entries writes the lower entry to address SPILL_BASE + n, where n is the spill depth before the push, and then increments n. The spill overlaps the fetch of the address bytes, so it adds no cycle.
- R7: A pop that finds no register entry, or an add or sub that finds fewer than two, reads entries back from SPILL_BASE + n − 1 and decrements n once per entry, until enough entries are in registers.
- R8: The cycle counts are: push 5, pop 3, add or sub 1, halt 1. Each fill adds 2 cycles. An add or sub that needed any fill costs 1 more cycle. The first fetch after reset costs 1 cycle.
- R9: A pop with no entry at all, or an add or sub with fewer than two entries in registers and spill region together, raises underflow and halted. Memory is left untouched.
- R10: A push with two register entries and a full spill region (n = SPILL_DEPTH) raises overflow and halted. No memory is written.
- R11: The data port never asserts read and write in the same cycle, and a read strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Instruction fetch byte address |
| imem_rdata | input | 8 | Instruction byte, one cycle after its address |
| dmem_addr | output | 16 | Data word address |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_wdata | output | DW | Data write word |
| dmem_rdata | input | DW | Data read word, one cycle after the strobe is seen |
| halted | output | 1 | Execution stopped (sticky) |
| underflow | output | 1 | Stack underflow seen (sticky) |
| overflow | output | 1 | Spill region overflow seen (sticky) |

## Verification
Each result of this core is due a fixed number of clock edges after reset release. That number is the sum of the per-instruction costs in R8: 5 per push, 3 per pop, 1 per arithmetic operation, 2 per fill and 1 more for an arithmetic operation that filled, plus one edge for the initial fetch and one for the stopping instruction. The bench counts edges from reset release and reads halted on the falling edge after each one. The count at which halted first appears must equal that sum, computed by a bench interpreter that also tracks the register count and spill depth. Memory contents, spill region included, are compared only after halted is seen, and again a fixed number of cycles later to show that nothing moved after the stop.

// File: rtl/sm_pkg.sv
package sm_pkg;
  localparam int ADDR_W = 16;

  localparam logic [7:0] OP_PUSH = 8'h01;
  localparam logic [7:0] OP_POP  = 8'h02;
  localparam logic [7:0] OP_ADD  = 8'h10;
  localparam logic [7:0] OP_SUB  = 8'h11;
  localparam logic [7:0] OP_HALT = 8'hFF;

  typedef enum logic [3:0] {
    S_PRIME, S_OP, S_A0, S_A1, S_PW, S_PD, S_FW, S_FD, S_EX, S_HALT
  } sm_state_e;

  typedef enum logic [2:0] {
    TC_NONE, TC_PUSH, TC_POP, TC_BIN, TC_FILL, TC_SPILL
  } tos_cmd_e;
endpackage

// File: rtl/sm_alu.sv
module sm_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  // a is the entry below the top, b is the top entry
  always_comb begin
    if (sub) y = a - b;
    else     y = a + b;
  end
endmodule

// File: rtl/sm_tos.sv
module sm_tos import sm_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  tos_cmd_e      cmd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top,
  output logic [DW-1:0] nxt,
  output logic [1:0]    vcnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      top  <= '0;
      nxt  <= '0;
      vcnt <= 2'd0;
    end else begin
      case (cmd)
        TC_PUSH: begin
          if (vcnt != 2'd0) nxt <= top;
          top  <= din;
          vcnt <= (vcnt == 2'd2) ? 2'd2 : vcnt + 2'd1;
        end
        TC_POP: begin
          top <= nxt;
          if (vcnt != 2'd0) vcnt <= vcnt - 2'd1;
        end
        TC_BIN: begin
          top  <= din;
          vcnt <= 2'd1;
        end
        TC_FILL: begin
          if (vcnt == 2'd0) begin
            top  <= din;
            vcnt <= 2'd1;
          end else begin
            nxt  <= din;
            vcnt <= 2'd2;
          end
        end
        TC_SPILL: vcnt <= 2'd1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sm_spill.sv
module sm_spill import sm_pkg::*; #(
  parameter int                SPILL_DEPTH = 16,
  parameter logic [ADDR_W-1:0] SPILL_BASE  = 16'hFF00,
  localparam int               CW          = $clog2(SPILL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  output logic [CW-1:0]     cnt,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + CW'(1);
    else if (dec) cnt <= cnt - CW'(1);
  end

  assign full    = (cnt == CW'(SPILL_DEPTH));
  assign empty   = (cnt == '0);
  assign wr_addr = SPILL_BASE + ADDR_W'(cnt);
  assign rd_addr = SPILL_BASE + ADDR_W'(cnt) - ADDR_W'(1);
endmodule

// File: rtl/sm_core.sv
module sm_core import sm_pkg::*; #(
  parameter int                DW          = 16,
  parameter int                SPILL_DEPTH = 16,
  parameter logic [ADDR_W-1:0] SPILL_BASE  = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [7:0]        imem_rdata,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic              dmem_we,
  output logic              dmem_re,
  output logic [DW-1:0]     dmem_wdata,
  input  logic [DW-1:0]     dmem_rdata,
  output logic              halted,
  output logic              underflow,
  output logic              overflow
);
  localparam int CW = $clog2(SPILL_DEPTH + 1);

  sm_state_e         state_q, nstate;
  logic [ADDR_W-1:0] pc_q;
  logic [7:0]        op_q, lo_q;

  tos_cmd_e          tcmd;
  logic [DW-1:0]     tdin, tos_top, tos_nxt;
  logic [1:0]        tos_vcnt;

  logic              sp_inc, sp_dec, sp_full, sp_empty;
  logic [CW-1:0]     sp_cnt;
  logic [ADDR_W-1:0] sp_wr_addr, sp_rd_addr;

  logic              alu_sub;
  logic [DW-1:0]     alu_y;

  logic              m_we, m_re;
  logic [ADDR_W-1:0] m_addr;
  logic [DW-1:0]     m_wdata;
  logic              set_uf, set_of;
  logic [31:0]       entries;
  logic [1:0]        need_fd;

  sm_tos #(.DW(DW)) u_tos (
    .clk(clk), .rst(rst), .cmd(tcmd), .din(tdin),
    .top(tos_top), .nxt(tos_nxt), .vcnt(tos_vcnt)
  );

  sm_spill #(.SPILL_DEPTH(SPILL_DEPTH), .SPILL_BASE(SPILL_BASE)) u_spill (
    .clk(clk), .rst(rst), .inc(sp_inc), .dec(sp_dec), .cnt(sp_cnt),
    .full(sp_full), .empty(sp_empty), .wr_addr(sp_wr_addr), .rd_addr(sp_rd_addr)
  );

  sm_alu #(.DW(DW)) u_alu (
    .a(tos_nxt), .b(tos_top), .sub(alu_sub), .y(alu_y)
  );

  assign alu_sub   = (state_q == S_EX) ? (op_q == OP_SUB) : (imem_rdata == OP_SUB);
  assign entries   = 32'(tos_vcnt) + 32'(sp_cnt);
  assign need_fd   = (op_q == OP_POP) ? 2'd1 : 2'd2;
  assign imem_addr = pc_q;

  always_comb begin
    nstate  = state_q;
    tcmd    = TC_NONE;
    tdin    = dmem_rdata;
    sp_inc  = 1'b0;
    sp_dec  = 1'b0;
    m_we    = 1'b0;
    m_re    = 1'b0;
    m_addr  = dmem_addr;
    m_wdata = dmem_wdata;
    set_uf  = 1'b0;
    set_of  = 1'b0;
    case (state_q)
      S_PRIME: nstate = S_OP;
      S_OP: begin
        case (imem_rdata)
          OP_PUSH: begin
            if (tos_vcnt == 2'd2) begin
              if (sp_full) begin
                set_of = 1'b1;
                nstate = S_HALT;
              end else begin
                m_we    = 1'b1;
                m_addr  = sp_wr_addr;
                m_wdata = tos_nxt;
                sp_inc  = 1'b1;
                tcmd    = TC_SPILL;
                nstate  = S_A0;
              end
            end else begin
              nstate = S_A0;
            end
          end
          OP_POP: begin
            if (tos_vcnt != 2'd0) begin
              nstate = S_A0;
            end else if (!sp_empty) begin
              m_re   = 1'b1;
              m_addr = sp_rd_addr;
              sp_dec = 1'b1;
              nstate = S_FW;
            end else begin
              set_uf = 1'b1;
              nstate = S_HALT;
            end
          end
          OP_ADD, OP_SUB: begin
            if (tos_vcnt == 2'd2) begin
              tcmd   = TC_BIN;
              tdin   = alu_y;
              nstate = S_OP;
            end else if (entries >= 32'd2) begin
              m_re   = 1'b1;
              m_addr = sp_rd_addr;
              sp_dec = 1'b1;
              nstate = S_FW;
            end else begin
              set_uf = 1'b1;
              nstate = S_HALT;
            end
          end
          default: nstate = S_HALT;
        endcase
      end
      S_A0: nstate = S_A1;
      S_A1: begin
        if (op_q == OP_PUSH) begin
          m_re   = 1'b1;
          m_addr = {imem_rdata, lo_q};
          nstate = S_PW;
        end else begin
          m_we    = 1'b1;
          m_addr  = {imem_rdata, lo_q};
          m_wdata = tos_top;
          tcmd    = TC_POP;
          nstate  = S_OP;
        end
      end
      S_PW: nstate = S_PD;
      S_PD: begin
        tcmd   = TC_PUSH;
        tdin   = dmem_rdata;
        nstate = S_OP;
      end
      S_FW: nstate = S_FD;
      S_FD: begin
        tcmd = TC_FILL;
        tdin = dmem_rdata;
        if ((tos_vcnt + 2'd1) < need_fd) begin
          m_re   = 1'b1;
          m_addr = sp_rd_addr;
          sp_dec = 1'b1;
          nstate = S_FW;
        end else begin
          nstate = (op_q == OP_POP) ? S_A0 : S_EX;
        end
      end
      S_EX: begin
        tcmd   = TC_BIN;
        tdin   = alu_y;
        nstate = S_OP;
      end
      default: nstate = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_PRIME;
      pc_q       <= '0;
      op_q       <= '0;
      lo_q       <= '0;
      dmem_addr  <= '0;
      dmem_we    <= 1'b0;
      dmem_re    <= 1'b0;
      dmem_wdata <= '0;
      halted     <= 1'b0;
      underflow  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      state_q    <= nstate;
      if (nstate == S_OP || nstate == S_A0 || nstate == S_A1) pc_q <= pc_q + ADDR_W'(1);
      if (state_q == S_OP) op_q <= imem_rdata;
      if (state_q == S_A0) lo_q <= imem_rdata;
      dmem_we    <= m_we;
      dmem_re    <= m_re;
      dmem_addr  <= m_addr;
      dmem_wdata <= m_wdata;
      if (nstate == S_HALT) halted <= 1'b1;
      if (set_uf) underflow <= 1'b1;
      if (set_of) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/sm_core_chk.sv
module sm_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] imem_addr,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        halted,
  input logic        underflow,
  input logic        overflow
);
  a_r11_one_access: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));
  a_r11_read_pulse: assert property (@(posedge clk) disable iff (rst)
    dmem_re |=> !dmem_re);
  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r5_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!dmem_we && !dmem_re));
  a_r5_halt_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(imem_addr));
  a_r9_uflow_halts: assert property (@(posedge clk) disable iff (rst)
    underflow |-> halted);
  a_r10_oflow_halts: assert property (@(posedge clk) disable iff (rst)
    overflow |-> halted);
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (imem_addr == $past(imem_addr)) || (imem_addr == $past(imem_addr) + 16'd1));
endmodule

bind sm_core sm_core_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .dmem_we(dmem_we),
  .dmem_re(dmem_re), .halted(halted), .underflow(underflow), .overflow(overflow)
);

// File: tb/tb_sm_core.sv
`timescale 1ns/1ps
module tb_sm_core;
  localparam int          DEPTH = 8;
  localparam logic [15:0] BASE  = 16'h0080;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [7:0]  imem_rdata;
  logic        dmem_we, dmem_re, halted, underflow, overflow;

  logic [7:0]  prog [256];
  logic [15:0] init_img [256];
  logic [15:0] dmem [256];
  logic [15:0] mdl [256];
  logic [15:0] snap [256];

  int total = 0, bad = 0, plen = 0, wd = 0;

  always #2.5 clk = ~clk;

  sm_core #(.DW(16), .SPILL_DEPTH(DEPTH), .SPILL_BASE(BASE)) dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .halted(halted), .underflow(underflow), .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    imem_rdata <= prog[imem_addr[7:0]];
    if (rst) begin
      for (int i = 0; i < 256; i++) dmem[i] <= init_img[i];
    end else if (dmem_we) begin
      dmem[dmem_addr[7:0]] <= dmem_wdata;
    end
    if (dmem_re) dmem_rdata <= dmem[dmem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'hFF;
    plen = 0;
  endtask
  task automatic emit(input logic [7:0] b);
    prog[plen] = b;
    plen++;
  endtask
  task automatic e_push(input logic [15:0] a);
    emit(8'h01); emit(a[7:0]); emit(a[15:8]);
  endtask
  task automatic e_pop(input logic [15:0] a);
    emit(8'h02); emit(a[7:0]); emit(a[15:8]);
  endtask

  // Bench interpreter built from R2-R10: memory effects, flags and cycle cost
  task automatic model_run(output int cyc, output bit uf, output bit of);
    logic [15:0] st [64];
    logic [15:0] a, r;
    int pc = 0, vc = 0, sp = 0, d = 0, k;
    bit done = 0;
    for (int i = 0; i < 256; i++) mdl[i] = init_img[i];
    cyc = 1; uf = 0; of = 0;
    while (!done) begin
      a = {prog[(pc + 2) % 256], prog[(pc + 1) % 256]};
      case (prog[pc % 256])
        8'h01: begin
          if (vc == 2 && sp == DEPTH) begin
            of = 1; cyc += 1; done = 1;
          end else begin
            if (vc == 2) begin
              mdl[BASE[7:0] + sp] = st[sp]; sp++; vc = 1;
            end
            st[d] = mdl[a[7:0]]; d++; vc++; cyc += 5; pc += 3;
          end
        end
        8'h02: begin
          if (d < 1) begin
            uf = 1; cyc += 1; done = 1;
          end else begin
            if (vc == 0) begin sp--; vc = 1; cyc += 2; end
            d--; mdl[a[7:0]] = st[d]; vc--; cyc += 3; pc += 3;
          end
        end
        8'h10, 8'h11: begin
          if (d < 2) begin
            uf = 1; cyc += 1; done = 1;
          end else begin
            k = 0;
            while (vc < 2) begin sp--; vc++; k++; end
            cyc += (k == 0) ? 1 : 2 + 2 * k;
            r = (prog[pc % 256] == 8'h11) ? st[d-2] - st[d-1] : st[d-2] + st[d-1];
            d--; st[d-1] = r; vc = 1; pc += 1;
          end
        end
        default: begin cyc += 1; done = 1; end
      endcase
    end
  endtask

  task automatic run_and_check(input string req, input bit rst_check, output int cyc);
    int mcyc, mism, first;
    bit muf, mof, ok;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    if (rst_check) begin
      chk(imem_addr == 16'd0 && !dmem_we && !dmem_re, "R1", "reset fetch/strobes", int'(imem_addr), 0);
      chk(!halted && !underflow && !overflow, "R1", "reset flags", int'({halted, underflow, overflow}), 0);
    end
    rst = 1'b0;
    cyc = 0; ok = 0;
    for (int i = 0; i < 4000 && !ok; i++) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (rst_check && cyc == 1)
        chk(!dmem_we && !dmem_re && !halted, "R1", "first cycle after reset quiet", int'({dmem_we, dmem_re, halted}), 0);
      if (halted) ok = 1;
    end
    chk(ok, "R5", "halted reached", int'(ok), 1);
    model_run(mcyc, muf, mof);
    chk(cyc == mcyc, "R8", {req, " cycles to halt"}, cyc, mcyc);
    chk(underflow == muf, "R9", {req, " underflow flag"}, int'(underflow), int'(muf));
    chk(overflow == mof, "R10", {req, " overflow flag"}, int'(overflow), int'(mof));
    mism = 0; first = -1;
    for (int i = 0; i < 256; i++) if (dmem[i] !== mdl[i]) begin mism++; if (first < 0) first = i; end
    if (first >= 0) $display("  word %0d actual=%0d expected=%0d", first, dmem[first], mdl[first]);
    chk(mism == 0, req, "memory words differing from model", mism, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        total++; bad++;
        $display("FAIL R5 watchdog expired actual=%0d expected=halt", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int cyc;
    logic [15:0] ia;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin init_img[i] = 16'h0; prog[i] = 8'hFF; end

    // Expression sequence A=B-C; B=A-C; D=A+B (A@0 B@1 C@2 D@3): R2 R3 R4
    init_img[1] = 16'd1000; init_img[2] = 16'd300;
    clear_prog();
    e_push(16'd1); e_push(16'd2); emit(8'h11); e_pop(16'd0);
    e_push(16'd0); e_push(16'd2); emit(8'h11); e_pop(16'd1);
    e_push(16'd0); e_push(16'd1); emit(8'h10); e_pop(16'd3);
    emit(8'hFF);
    run_and_check("R3", 1'b1, cyc);
    chk(dmem[0] == 16'd700, "R4", "A=B-C", int'(dmem[0]), 700);
    chk(dmem[1] == 16'd400, "R4", "B=A-C", int'(dmem[1]), 400);
    chk(dmem[3] == 16'd1100, "R4", "D=A+B", int'(dmem[3]), 1100);
    chk(cyc == 1 + 6*5 + 3*3 + 3 + 1, "R8", "expression cycles", cyc, 1 + 30 + 9 + 3 + 1);

    // R5: nothing moves after halt
    for (int i = 0; i < 256; i++) snap[i] = dmem[i];
    ia = imem_addr;
    repeat (20) @(negedge clk);
    begin
      int diff = 0;
      for (int i = 0; i < 256; i++) if (dmem[i] !== snap[i]) diff++;
      chk(diff == 0 && imem_addr == ia && halted, "R5", "state frozen after halt", diff, 0);
    end

    // R6: five pushes spill three oldest in order
    for (int i = 0; i < 256; i++) init_img[i] = 16'h0;
    for (int i = 0; i < 8; i++) init_img[i] = 16'(11 * (i + 1));
    clear_prog();
    for (int i = 0; i < 5; i++) e_push(16'(i));
    emit(8'hFF);
    run_and_check("R6", 1'b0, cyc);
    chk(dmem[BASE[7:0]] == 16'd11, "R6", "spill slot 0", int'(dmem[BASE[7:0]]), 11);
    chk(dmem[BASE[7:0]+1] == 16'd22, "R6", "spill slot 1", int'(dmem[BASE[7:0]+1]), 22);
    chk(dmem[BASE[7:0]+2] == 16'd33, "R6", "spill slot 2", int'(dmem[BASE[7:0]+2]), 33);
    chk(cyc == 27, "R6", "spill adds no cycle", cyc, 27);

    // R7: fills on pop and on sub
    clear_prog();
    e_push(16'd0); e_push(16'd1); e_push(16'd2);
    e_pop(16'd8); e_pop(16'd9); e_pop(16'd10);
    e_push(16'd10); e_push(16'd9); e_push(16'd8);
    emit(8'h10); emit(8'h11); e_pop(16'd11);
    emit(8'hFF);
    run_and_check("R7", 1'b0, cyc);
    chk(dmem[8] == 16'd33 && dmem[9] == 16'd22, "R7", "pops from registers", int'(dmem[9]), 22);
    chk(dmem[10] == 16'd11, "R7", "pop refilled from spill", int'(dmem[10]), 11);
    chk(dmem[11] == 16'hFFD4, "R7", "sub refilled second entry", int'(dmem[11]), 16'hFFD4);
    chk(cyc == 51, "R8", "fill cycle cost", cyc, 51);

    // R9: underflow on add with one entry, then pop on empty
    clear_prog(); e_push(16'd0); emit(8'h10);
    run_and_check("R9", 1'b0, cyc);
    chk(underflow && halted && cyc == 7, "R9", "add underflow", cyc, 7);
    clear_prog(); e_pop(16'd5);
    run_and_check("R9", 1'b0, cyc);
    chk(underflow && dmem[5] == 16'd66 && cyc == 2, "R9", "pop on empty stack", int'(dmem[5]), 66);

    // R10: eleventh push with DEPTH=8 overflows
    clear_prog();
    for (int i = 0; i < 11; i++) e_push(16'(i % 8));
    run_and_check("R10", 1'b0, cyc);
    chk(overflow && !underflow && cyc == 52, "R10", "overflow cycle", cyc, 52);

    // R5: undefined opcode stops the core
    clear_prog(); e_push(16'd2); e_pop(16'd7); emit(8'h42); e_pop(16'd6);
    run_and_check("R5", 1'b0, cyc);
    chk(halted && !underflow && !overflow && dmem[6] == 16'd77, "R5", "undefined opcode halts", int'(dmem[6]), 77);

    // Random programs: R2 R3 R4 R6 R7 R8
    for (int t = 0; t < 25; t++) begin
      int d = 0, n;
      for (int i = 0; i < 256; i++) init_img[i] = 16'h0;
      for (int i = 0; i < 16; i++) init_img[i] = 16'($urandom);
      for (int i = 0; i < DEPTH; i++) init_img[BASE[7:0] + i] = 16'($urandom);
      clear_prog();
      n = 8 + int'($urandom % 12);
      for (int s = 0; s < n; s++) begin
        int r = int'($urandom % 4);
        if (d == 0 || (d < 8 && r < 2)) begin e_push(16'($urandom % 16)); d++; end
        else if (d == 1 || r == 2) begin e_pop(16'($urandom % 16)); d--; end
        else begin emit(($urandom % 2) ? 8'h11 : 8'h10); d--; end
      end
      emit(8'hFF);
      run_and_check("R7", 1'b0, cyc);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule